// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block runs the memory side of a load-multiple or store-multiple operation. Given a register-select mask, a base address, the index of the base register and five mode bits (pre-step, ascending, load, writeback, user bank), it walks the selected registers one per cycle. For each one it issues a single word access on a zero-wait bus and labels the access as sequential or non-sequential.

On loads it hands each returned word, with its register index, to the register file. On stores it names the register to read and drives that register's value onto the bus. When the walk ends it raises a one-cycle completion pulse carrying the updated base value and a flag that says whether the base may be written back.

A new operation is accepted only while the block is idle. Every input is captured at acceptance, so the caller may change its inputs once the block is busy.

Top module: `blk_xfer_seq`

## Requirements
- R1: Selected registers are visited in ascending index order (0 first) when the ascending bit is 1, and in descending order (15 first) when it is 0. Each access cycle reports its register index on `ld_idx_o` for loads and on `rf_raddr_o` for stores.
- R2: Consecutive data addresses differ by +4 when ascending and by -4 otherwise. With the pre-step bit set, the first address is base±4. With it clear, the first address is the base itself.
- R3: Exactly one bus access is made per set bit of the mask, with `bus_we_o`=1 for stores and 0 for loads. On a load, `ld_data_o` equals `bus_rdata_i` in the same cycle, and `ld_valid_o` is high.
- R4: The first data access of an operation has `bus_seq_o`=0, and every later data access has `bus_seq_o`=1.
- R5: After the last store access, the block makes one extra read access (`bus_we_o`=0, `bus_seq_o`=0) at instruction address + 8. Loads have no such access.
- R6: A store of register 15 drives instruction address + 12 on `bus_wdata_o`. Any other register drives `rf_rdata_i`.
- R7: An all-zero mask transfers register 15 alone, at the base address whatever the pre-step bit. The reported base value is then base+0x40 when ascending and base-0x40 otherwise.
- R8: For a non-empty mask with n set bits, the reported base value is base±4n, with the sign set by the ascending bit. `wb_en_o` equals the writeback bit, except that it is 0 on a load whose mask includes the base register index.
- R9: With the user-bank bit, `rf_user_o` (stores) and `ld_user_o` (loads) are 1 during every data access, unless the operation is a load with bit 15 set. In that case they stay 0, and `psr_restore_o` pulses in the cycle where register 15 is loaded.
- R10: `done_o` is high for exactly one cycle, the cycle after the final bus access. `wb_en_o` and `wb_val_o` are valid only in that cycle. `busy_o` is high from the cycle after acceptance through the done cycle.
- R11: `start_i` is ignored while `busy_o` is high. An operation under way is not altered by new inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a new operation (taken when idle) |
| reg_list_i | input | 16 | Register select mask |
| base_idx_i | input | 4 | Index of the base register |
| base_i | input | 32 | Base address |
| insn_addr_i | input | 32 | Address of the instruction being executed |
| pre_i | input | 1 | Step the address before each access |
| asc_i | input | 1 | Ascending walk and positive step |
| load_i | input | 1 | 1 = load, 0 = store |
| wb_i | input | 1 | Writeback requested |
| user_i | input | 1 | User-bank transfer request |
| busy_o | output | 1 | Operation in progress |
| bus_req_o | output | 1 | Bus access this cycle |
| bus_we_o | output | 1 | Access is a write |
| bus_seq_o | output | 1 | Access is sequential |
| bus_addr_o | output | 32 | Access address |
| bus_wdata_o | output | 32 | Store data |
| bus_rdata_i | input | 32 | Load data (same cycle) |
| rf_raddr_o | output | 4 | Register index to read for a store |
| rf_user_o | output | 1 | Read from the user bank |
| rf_rdata_i | input | 32 | Register read data |
| ld_valid_o | output | 1 | Load data valid for the register file |
| ld_idx_o | output | 4 | Register index being loaded |
| ld_data_o | output | 32 | Loaded word |
| ld_user_o | output | 1 | Write into the user bank |
| psr_restore_o | output | 1 | Copy saved status into current status |
| done_o | output | 1 | Completion pulse |
| wb_en_o | output | 1 | Write the base value back |
| wb_val_o | output | 32 | Updated base value |

## Verification
A corrupted remaining-register mask shows up at once as a skipped, repeated or out-of-order index on `ld_idx_o`/`rf_raddr_o`, and the extra or missing access moves `done_o` by a cycle. A wrong running address shows in the next access, as an address step other than ±4. It then shows again at completion, where the running address no longer matches the precomputed base value. Errors in the captured mode bits show in the first access cycle, through the address, write enable, sequential label or bank flags. Captured writeback state is seen only in the done cycle.

// File: rtl/bxs_pkg.sv
package bxs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_XFER,
    ST_TAIL,
    ST_DONE
  } bxs_state_e;
endpackage

// File: rtl/bxs_pick.sv
module bxs_pick #(
  parameter int NREG       = 16,
  parameter bit HIGH_FIRST = 1'b0,
  parameter int IW         = $clog2(NREG)
) (
  input  logic [NREG-1:0] mask_i,
  output logic            valid_o,
  output logic [IW-1:0]   idx_o
);
  generate
    if (HIGH_FIRST) begin : g_high
      always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        for (int i = 0; i < NREG; i++) begin
          if (mask_i[i]) begin
            valid_o = 1'b1;
            idx_o   = IW'(i);
          end
        end
      end
    end else begin : g_low
      always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
          if (mask_i[i]) begin
            valid_o = 1'b1;
            idx_o   = IW'(i);
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/bxs_addr.sv
module bxs_addr #(
  parameter int AW   = 32,
  parameter int WB   = 4,
  parameter int NREG = 16,
  parameter int CW   = $clog2(NREG) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic [AW-1:0] base_i,
  input  logic          asc_i,
  input  logic          pre_i,
  input  logic          empty_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          adv_i,
  input  logic          fin_i,
  output logic [AW-1:0] acc_addr_o,
  output logic [AW-1:0] final_o
);
  localparam logic [AW-1:0] STEP  = AW'(WB);
  localparam logic [AW-1:0] SPAN0 = AW'(NREG * WB);

  logic [AW-1:0] cur_q, final_q, step_w, delta_w;
  logic          asc_q, pre_q, empty_q;

  assign step_w  = asc_q ? STEP : -STEP;
  assign delta_w = empty_i ? SPAN0 : (AW'(cnt_i) * STEP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q   <= '0;
      final_q <= '0;
      asc_q   <= 1'b0;
      pre_q   <= 1'b0;
      empty_q <= 1'b0;
    end else if (cap_i) begin
      cur_q   <= base_i;
      final_q <= asc_i ? base_i + delta_w : base_i - delta_w;
      asc_q   <= asc_i;
      pre_q   <= pre_i;
      empty_q <= empty_i;
    end else if (adv_i) begin
      cur_q <= cur_q + step_w;
    end
  end

  // empty list accesses the unstepped base
  assign acc_addr_o = (pre_q && !empty_q) ? cur_q + step_w : cur_q;
  assign final_o    = final_q;

  // R8: running address lands on the precomputed base value
  a_r8_final_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin_i && !empty_q) |-> (cur_q == final_q));
endmodule

// File: rtl/bxs_ctrl.sv
module bxs_ctrl
  import bxs_pkg::*;
#(
  parameter int NREG = 16,
  parameter int IW   = $clog2(NREG),
  parameter int CW   = $clog2(NREG) + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [NREG-1:0] list_i,
  input  logic [IW-1:0]   base_idx_i,
  input  logic            asc_i,
  input  logic            load_i,
  input  logic            wb_i,
  input  logic            user_i,
  output logic            cap_o,
  output logic            empty_o,
  output logic [CW-1:0]   cnt_o,
  output logic            xfer_o,
  output logic            tail_o,
  output logic            done_o,
  output logic            busy_o,
  output logic [IW-1:0]   idx_o,
  output logic            seq_o,
  output logic            asc_o,
  output logic            load_o,
  output logic            user_o,
  output logic            psr_o,
  output logic            wb_en_o
);
  localparam int PC = NREG - 1;

  bxs_state_e      state_q;
  logic [NREG-1:0] mask_q, mask_nx;
  logic            first_q, asc_q, load_q, user_q, psr_q, wb_en_q;
  logic [1:0]      pv;
  logic [IW-1:0]   pidx [2];

  function automatic logic [CW-1:0] popc(logic [NREG-1:0] v);
    popc = '0;
    for (int i = 0; i < NREG; i++) popc = popc + CW'(v[i]);
  endfunction

  // [0] lowest-first, [1] highest-first
  generate
    for (genvar g = 0; g < 2; g++) begin : g_pick
      bxs_pick #(.NREG(NREG), .HIGH_FIRST(g == 1), .IW(IW)) u_pick (
        .mask_i (mask_q),
        .valid_o(pv[g]),
        .idx_o  (pidx[g])
      );
    end
  endgenerate

  assign idx_o   = asc_q ? pidx[0] : pidx[1];
  assign mask_nx = mask_q & ~(NREG'(1) << idx_o);
  assign cap_o   = start_i && (state_q == ST_IDLE);
  assign empty_o = (list_i == '0);
  assign cnt_o   = popc(list_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mask_q  <= '0;
      first_q <= 1'b0;
      asc_q   <= 1'b0;
      load_q  <= 1'b0;
      user_q  <= 1'b0;
      psr_q   <= 1'b0;
      wb_en_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (cap_o) begin
          state_q <= ST_XFER;
          mask_q  <= empty_o ? (NREG'(1) << PC) : list_i;
          first_q <= 1'b1;
          asc_q   <= asc_i;
          load_q  <= load_i;
          user_q  <= user_i && !(load_i && list_i[PC]);
          psr_q   <= user_i && load_i && list_i[PC];
          wb_en_q <= wb_i && !(load_i && list_i[base_idx_i]);
        end
        ST_XFER: begin
          mask_q  <= mask_nx;
          first_q <= 1'b0;
          if (mask_nx == '0) state_q <= load_q ? ST_DONE : ST_TAIL;
        end
        ST_TAIL: state_q <= ST_DONE;
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign xfer_o  = (state_q == ST_XFER);
  assign tail_o  = (state_q == ST_TAIL);
  assign done_o  = (state_q == ST_DONE);
  assign busy_o  = (state_q != ST_IDLE);
  assign seq_o   = xfer_o && !first_q;
  assign asc_o   = asc_q;
  assign load_o  = load_q;
  assign user_o  = user_q;
  assign psr_o   = xfer_o && psr_q && (idx_o == IW'(PC));
  assign wb_en_o = done_o && wb_en_q;

  // R1: chosen register is pending in the mask
  a_r1_pick_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |-> (pv[0] && pv[1] && mask_q[idx_o]));
  // R3: one register retired per access cycle
  a_r3_one_per_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |=> ($countones(mask_q) + 1 == $past($countones(mask_q))));
  // R10: completion is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R11: a request while busy starts nothing
  a_r11_busy_ignores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq #(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int NREG      = 16,
  parameter int STORE_OFS = 12,
  parameter int FETCH_OFS = 8,
  parameter int IW        = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [NREG-1:0] reg_list_i,
  input  logic [IW-1:0]   base_idx_i,
  input  logic [AW-1:0]   base_i,
  input  logic [AW-1:0]   insn_addr_i,
  input  logic            pre_i,
  input  logic            asc_i,
  input  logic            load_i,
  input  logic            wb_i,
  input  logic            user_i,
  output logic            busy_o,
  output logic            bus_req_o,
  output logic            bus_we_o,
  output logic            bus_seq_o,
  output logic [AW-1:0]   bus_addr_o,
  output logic [DW-1:0]   bus_wdata_o,
  input  logic [DW-1:0]   bus_rdata_i,
  output logic [IW-1:0]   rf_raddr_o,
  output logic            rf_user_o,
  input  logic [DW-1:0]   rf_rdata_i,
  output logic            ld_valid_o,
  output logic [IW-1:0]   ld_idx_o,
  output logic [DW-1:0]   ld_data_o,
  output logic            ld_user_o,
  output logic            psr_restore_o,
  output logic            done_o,
  output logic            wb_en_o,
  output logic [AW-1:0]   wb_val_o
);
  localparam int WB = DW / 8;
  localparam int CW = IW + 1;
  localparam int PC = NREG - 1;

  logic          cap, empty, xfer, tail, done, seq, asc, load, user, psr, wb_en;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic [AW-1:0] acc_addr, final_val, pc_q, step_w;

  bxs_ctrl #(.NREG(NREG), .IW(IW), .CW(CW)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .list_i    (reg_list_i),
    .base_idx_i(base_idx_i),
    .asc_i     (asc_i),
    .load_i    (load_i),
    .wb_i      (wb_i),
    .user_i    (user_i),
    .cap_o     (cap),
    .empty_o   (empty),
    .cnt_o     (cnt),
    .xfer_o    (xfer),
    .tail_o    (tail),
    .done_o    (done),
    .busy_o    (busy_o),
    .idx_o     (idx),
    .seq_o     (seq),
    .asc_o     (asc),
    .load_o    (load),
    .user_o    (user),
    .psr_o     (psr),
    .wb_en_o   (wb_en)
  );

  bxs_addr #(.AW(AW), .WB(WB), .NREG(NREG), .CW(CW)) u_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cap_i     (cap),
    .base_i    (base_i),
    .asc_i     (asc_i),
    .pre_i     (pre_i),
    .empty_i   (empty),
    .cnt_i     (cnt),
    .adv_i     (xfer),
    .fin_i     (done),
    .acc_addr_o(acc_addr),
    .final_o   (final_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  pc_q <= '0;
    else if (cap) pc_q <= insn_addr_i;
  end

  assign bus_req_o   = xfer || tail;
  assign bus_we_o    = xfer && !load;
  assign bus_seq_o   = seq;
  assign bus_addr_o  = xfer ? acc_addr : (tail ? pc_q + AW'(FETCH_OFS) : '0);
  assign bus_wdata_o = (xfer && !load)
                     ? ((idx == IW'(PC)) ? DW'(pc_q + AW'(STORE_OFS)) : rf_rdata_i)
                     : '0;
  assign rf_raddr_o  = idx;
  assign rf_user_o   = xfer && !load && user;
  assign ld_valid_o  = xfer && load;
  assign ld_idx_o    = idx;
  assign ld_data_o   = bus_rdata_i;
  assign ld_user_o   = xfer && load && user;
  assign psr_restore_o = psr;
  assign done_o      = done;
  assign wb_en_o     = wb_en;
  assign wb_val_o    = done ? final_val : '0;

  assign step_w = asc ? AW'(WB) : -AW'(WB);

  // R2: back-to-back data accesses move by one word in the walk direction
  a_r2_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer && $past(xfer)) |-> (bus_addr_o == $past(bus_addr_o) + step_w));
  // R4: later data accesses are sequential
  a_r4_seq_after_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer && $past(xfer)) |-> bus_seq_o);
  // R5: closing access is a non-sequential read
  a_r5_tail_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tail |-> (bus_req_o && !bus_we_o && !bus_seq_o));
  // R9: status restore never coincides with a user-bank transfer
  a_r9_restore_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psr_restore_o |-> (!ld_user_o && ld_valid_o));
endmodule

// File: tb/tb_blk_xfer_seq.sv
module tb_blk_xfer_seq;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYC    = 200000;

  logic        clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [15:0] reg_list_i = '0;
  logic [3:0]  base_idx_i = '0;
  logic [31:0] base_i = '0, insn_addr_i = '0;
  logic        pre_i = 0, asc_i = 0, load_i = 0, wb_i = 0, user_i = 0;
  logic        busy_o, bus_req_o, bus_we_o, bus_seq_o;
  logic [31:0] bus_addr_o, bus_wdata_o, bus_rdata_i, rf_rdata_i, ld_data_o, wb_val_o;
  logic [3:0]  rf_raddr_o, ld_idx_o;
  logic        rf_user_o, ld_valid_o, ld_user_o, psr_restore_o, done_o, wb_en_o;

  int errors = 0, checks = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  assign bus_rdata_i = ~bus_addr_o;
  assign rf_rdata_i  = {16'hC0DE, 7'h0, rf_user_o, 4'h0, rf_raddr_o};

  blk_xfer_seq dut (.*);

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > MAX_CYC) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, MAX_CYC);
      summary();
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(logic [15:0] lst, logic [3:0] bidx, logic [31:0] base,
                     logic [31:0] pc, logic pre, logic asc, logic ld,
                     logic wb, logic usr, logic junk);
    logic [15:0] eff;
    logic [31:0] step, cur, ea, efin;
    logic        ux, first;
    int          n;
    eff  = (lst == 0) ? 16'h8000 : lst;
    step = asc ? 32'd4 : -32'd4;
    ux   = usr && !(ld && lst[15]);
    n    = $countones(lst);
    efin = (lst == 0) ? (asc ? base + 32'h40 : base - 32'h40)
                      : base + step * n;
    @(negedge clk_i);
    start_i = 1; reg_list_i = lst; base_idx_i = bidx; base_i = base;
    insn_addr_i = pc; pre_i = pre; asc_i = asc; load_i = ld; wb_i = wb; user_i = usr;
    @(negedge clk_i);
    if (junk) begin
      start_i = 1; reg_list_i = ~lst; base_i = ~base; insn_addr_i = ~pc;
      pre_i = ~pre; asc_i = ~asc; load_i = ~ld; wb_i = ~wb; user_i = ~usr;
    end else start_i = 0;
    cur = base; first = 1;
    for (int i = 0; i < 16; i++) begin
      int r;
      r = asc ? i : 15 - i;
      if (eff[r]) begin
        if (!first) @(negedge clk_i);
        ea = (pre && lst != 0) ? cur + step : cur;
        cur = cur + step;
        chk("R3 req", bus_req_o, 1);
        chk("R3 we", bus_we_o, !ld);
        chk("R4 seq", bus_seq_o, !first);
        chk("R2 addr", bus_addr_o, ea);
        if (lst == 0) chk("R7 empty addr", bus_addr_o, base);
        if (ld) begin
          chk("R1 ld_idx", ld_idx_o, r);
          chk("R3 ld_valid", ld_valid_o, 1);
          chk("R3 ld_data", ld_data_o, ~ea);
          chk("R9 ld_user", ld_user_o, ux);
          chk("R9 psr", psr_restore_o, usr && lst[15] && r == 15);
        end else begin
          chk("R1 rf_raddr", rf_raddr_o, r);
          chk("R9 rf_user", rf_user_o, ux);
          chk("R6 wdata", bus_wdata_o,
              (r == 15) ? pc + 12 : {16'hC0DE, 7'h0, ux, 4'h0, 4'(r)});
        end
        chk("R10 no early done", done_o, 0);
        first = 0;
      end
    end
    if (!ld) begin
      @(negedge clk_i);
      chk("R5 tail req", bus_req_o, 1);
      chk("R5 tail we", bus_we_o, 0);
      chk("R5 tail seq", bus_seq_o, 0);
      chk("R5 tail addr", bus_addr_o, pc + 8);
    end
    @(negedge clk_i);
    start_i = 0;
    chk("R10 done", done_o, 1);
    chk("R10 busy in done", busy_o, 1);
    chk("R10 no access in done", bus_req_o, 0);
    chk(lst == 0 ? "R7 empty wb_val" : "R8 wb_val", wb_val_o, efin);
    chk("R8 wb_en", wb_en_o, wb && !(ld && lst[bidx]));
    @(negedge clk_i);
    chk(junk ? "R11 idle after busy start" : "R10 idle", busy_o, 0);
    chk("R10 done low", done_o, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #(CLK_PERIOD * 2 + 1);
    chk("R10 reset busy", busy_o, 0);
    chk("R10 reset done", done_o, 0);
    chk("R3 reset req", bus_req_o, 0);
    rst_ni = 1;
    // directed corners
    run(16'h8011, 4'd2, 32'h0000_1000, 32'h0000_0200, 1, 1, 0, 1, 0, 0); // R1 R2 R6
    run(16'h00F0, 4'd5, 32'h0000_2000, 32'h0000_0300, 0, 0, 1, 1, 0, 0); // R8 base in list
    run(16'h0000, 4'd1, 32'h0000_3000, 32'h0000_0400, 1, 1, 0, 1, 0, 0); // R7 store
    run(16'h0000, 4'd1, 32'h0000_3000, 32'h0000_0400, 1, 0, 1, 1, 0, 0); // R7 load
    run(16'hFFFF, 4'd0, 32'h0000_4000, 32'h0000_0500, 0, 1, 1, 1, 0, 0); // full list
    run(16'h8003, 4'd9, 32'h0000_5000, 32'h0000_0600, 1, 0, 1, 1, 1, 0); // R9 restore
    run(16'h0302, 4'd9, 32'h0000_6000, 32'h0000_0700, 0, 0, 0, 1, 1, 0); // R9 user store
    run(16'h0420, 4'd3, 32'h0000_7000, 32'h0000_0800, 1, 1, 1, 0, 0, 1); // R11 junk
    run(16'h0001, 4'd3, 32'h0000_0004, 32'h0000_0900, 1, 0, 0, 1, 0, 1); // single, R11
    for (int k = 0; k < 60; k++) begin
      run(16'($urandom()), 4'($urandom()), $urandom() & 32'hFFFF_FFFC,
          $urandom() & 32'h00FF_FFFC, 1'($urandom()), 1'($urandom()),
          1'($urandom()), 1'($urandom()), 1'($urandom()), 1'($urandom()));
    end
    summary();
  end
endmodule